// File: doc/BRIEF.md
# Backlight PWM with Commit-Staged Settings

This block generates one pulse-width-modulated output for a display backlight. Software programs it through a small synchronous register bus with an address, write data, a write strobe and combinational read data. Three settings shape the waveform: a clock prescaler, a period count and a high-time count. Software writes them into staging registers, and they do not affect the output while they sit there.

A rising edge on the commit bit moves all three staged values into the active copies in one step. While the generator runs, the move waits for the end of the period in progress. That period therefore finishes with the old values, and no period ever mixes old and new settings. While the generator is disabled, the move happens at once. The enable bit gates the output. When the enable bit turns on, the counters start again from zero, so the first period opens with its full high phase.

Top module: `bl_pwm`

## Requirements
- R1: After reset every register reads zero, the staged and active settings are zero, and `pwm_out` is low.
- R2: Register map (byte addresses). Offset 0x00 bit 0 is enable. Offset 0x08 bit 0 is commit. Offset 0x10 bits 25:16 hold the prescaler. Offset 0x14 bits 11:0 hold the period and bits 28:16 hold the high width. Reads return the staged values. Unused bits and unmapped offsets read zero, and writes to unused bits have no effect.
- R3: While enable is 0, `pwm_out` is low, whatever the active settings are.
- R4: While enabled, one output period lasts (prescaler+1)×(period+1) clocks. The output is high for the first (prescaler+1)×(high+1) clocks of each period and low for the rest.
- R5: When high is greater than or equal to period, the output stays high for the whole period.
- R6: Writing the staged settings without a commit leaves the waveform unchanged.
- R7: A 0→1 transition of the commit bit while running loads all staged settings together at the next period boundary. The period in progress completes with the old settings.
- R8: A 0→1 transition of the commit bit while disabled loads the staged settings at once.
- R9: When enable goes from 0 to 1, the prescaler and period counters restart from zero, and the first period begins with its full high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| pwm_out | output | 1 | PWM output |

## Verification
The waveform is checked sample by sample against the period and high-time formulas for several settings:
- A plain divided setting (prescaler 1) separates prescaler handling from period handling.
- An undivided setting with a short duty checks the compare point.
- A three-way prescaled setting confirms that the prescaler stretches both the period and the high time.
- Settings with high equal to and greater than period exercise full duty.

A fixed sixteen-sample sequence, with a commit issued early in an eight-clock period, tells a boundary-aligned load apart from an immediate or lost one. Staging without a commit, disabling with full duty active, and a quick disable/enable in mid-period separate the staging, gating and restart behaviours.

// File: rtl/bl_pwm.sv
module bl_pwm #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int DIV_W   = 10,
  parameter int PER_W   = 12,
  parameter int HI_W    = 13,
  parameter int DIV_LSB = 16,
  parameter int HI_LSB  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out
);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_CMT = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_DIV = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_TIM = ADDR_W'('h14);
  localparam int CMP_W = (HI_W > PER_W) ? HI_W : PER_W;

  logic             en_q, cmt_q, pend;
  logic [DIV_W-1:0] stg_div, act_div, pc;
  logic [PER_W-1:0] stg_per, act_per, cnt;
  logic [HI_W-1:0]  stg_hi, act_hi;

  wire wr_en  = bus_we && bus_addr == A_EN;
  wire wr_cmt = bus_we && bus_addr == A_CMT;
  wire wr_div = bus_we && bus_addr == A_DIV;
  wire wr_tim = bus_we && bus_addr == A_TIM;

  wire commit_rise = wr_cmt && bus_wdata[0] && !cmt_q;
  wire step        = pc == act_div;
  wire wrap        = step && cnt == act_per;
  wire load        = (pend || commit_rise) && (!en_q || wrap);

  logic unused_wdata;
  assign unused_wdata = &{1'b0, bus_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      cmt_q   <= 1'b0;
      stg_div <= '0;
      stg_per <= '0;
      stg_hi  <= '0;
    end else begin
      if (wr_en)  en_q    <= bus_wdata[0];
      if (wr_cmt) cmt_q   <= bus_wdata[0];
      if (wr_div) stg_div <= bus_wdata[DIV_LSB +: DIV_W];
      if (wr_tim) begin
        stg_per <= bus_wdata[PER_W-1:0];
        stg_hi  <= bus_wdata[HI_LSB +: HI_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      act_div <= '0;
      act_per <= '0;
      act_hi  <= '0;
    end else if (load) begin
      pend    <= 1'b0;
      act_div <= stg_div;
      act_per <= stg_per;
      act_hi  <= stg_hi;
    end else if (commit_rise) begin
      pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en_q) begin
      pc  <= '0;
      cnt <= '0;
    end else if (step) begin
      pc  <= '0;
      cnt <= wrap ? '0 : cnt + PER_W'(1);
    end else begin
      pc  <= pc + DIV_W'(1);
    end
  end

  assign pwm_out = en_q && (CMP_W'(cnt) <= CMP_W'(act_hi));

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_EN:  bus_rdata[0] = en_q;
      A_CMT: bus_rdata[0] = cmt_q;
      A_DIV: bus_rdata[DIV_LSB +: DIV_W] = stg_div;
      A_TIM: begin
        bus_rdata[PER_W-1:0]      = stg_per;
        bus_rdata[HI_LSB +: HI_W] = stg_hi;
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk #(
  parameter int DIV_W = 10,
  parameter int PER_W = 12,
  parameter int HI_W  = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic             pwm_out,
  input logic [DIV_W-1:0] pc,
  input logic [DIV_W-1:0] act_div,
  input logic [PER_W-1:0] cnt,
  input logic [PER_W-1:0] act_per,
  input logic [HI_W-1:0]  act_hi
);
  localparam int CMP_W = (HI_W > PER_W) ? HI_W : PER_W;

  p_low_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !pwm_out);

  p_count_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (pc <= act_div && cnt <= act_per));

  p_full_duty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && CMP_W'(act_hi) >= CMP_W'(act_per)) |-> pwm_out);

  p_active_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !(pc == act_div && cnt == act_per)) |=> $stable({act_div, act_per, act_hi}));

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> (pc == '0 && cnt == '0 && pwm_out));
endmodule

bind bl_pwm bl_pwm_chk #(.DIV_W(DIV_W), .PER_W(PER_W), .HI_W(HI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .pwm_out(pwm_out),
  .pc(pc), .act_div(act_div), .cnt(cnt), .act_per(act_per), .act_hi(act_hi)
);

// File: tb/tb_bl_pwm.sv
module tb_bl_pwm;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  int checks = 0;
  int failures = 0;

  bl_pwm dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
              .bus_we(bus_we), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, $sformatf("read 0x%0h", a), bus_rdata, exp);
  endtask

  function automatic logic exp_bit(input int i, input int dv, input int pr, input int hi);
    return ((i / (dv + 1)) % (pr + 1)) <= hi;
  endfunction

  task automatic stage(input int dv, input int pr, input int hi);
    wr(8'h10, 32'(dv) << 16);
    wr(8'h14, (32'(hi) << 16) | 32'(pr));
  endtask

  task automatic commit();
    wr(8'h08, 32'd1);
    wr(8'h08, 32'd0);
  endtask

  // Call at a negedge right after enable took effect; samples n clocks.
  task automatic sample_cmp(input string req, input int n, input int dv, input int pr, input int hi);
    int bad = 0;
    int bad_i = -1;
    logic bad_act = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out !== exp_bit(i, dv, pr, hi)) begin
        if (bad == 0) begin bad_i = i; bad_act = pwm_out; end
        bad++;
      end
      @(negedge clk);
    end
    check(req, $sformatf("waveform div=%0d per=%0d hi=%0d first bad sample %0d", dv, pr, hi, bad_i),
          bad == 0 ? 0 : bad_act, bad == 0 ? 0 : exp_bit(bad_i, dv, pr, hi));
  endtask

  task automatic t_reset();
    rd_check("R1", 8'h00, 0);
    rd_check("R1", 8'h08, 0);
    rd_check("R1", 8'h10, 0);
    rd_check("R1", 8'h14, 0);
    check("R1", "pwm_out after reset", pwm_out, 0);
  endtask

  task automatic t_regmap();
    wr(8'h08, 32'hFFFF_FFFF); rd_check("R2", 8'h08, 32'h1);
    wr(8'h08, 32'h0);
    wr(8'h10, 32'hFFFF_FFFF); rd_check("R2", 8'h10, 32'h03FF_0000);
    wr(8'h14, 32'hFFFF_FFFF); rd_check("R2", 8'h14, 32'h1FFF_0FFF);
    wr(8'h04, 32'hFFFF_FFFF); rd_check("R2", 8'h04, 32'h0);
    wr(8'h00, 32'hFFFF_FFFE); rd_check("R2", 8'h00, 32'h0);
    check("R2", "pwm_out with enable bit 0 written", pwm_out, 0);
  endtask

  task automatic run_pattern(input string req, input int dv, input int pr, input int hi);
    wr(8'h00, 0);
    stage(dv, pr, hi);
    commit();
    wr(8'h00, 1);
    sample_cmp(req, 2 * (dv + 1) * (pr + 1), dv, pr, hi);
  endtask

  task automatic t_patterns();
    run_pattern("R4", 1, 3, 1);
    run_pattern("R4", 0, 4, 1);
    run_pattern("R4_R8", 2, 2, 0);
    run_pattern("R5", 0, 3, 3);
    run_pattern("R5", 1, 2, 9);
  endtask

  task automatic t_disabled_low();
    int highs = 0;
    wr(8'h00, 0);
    for (int i = 0; i < 12; i++) begin
      highs += pwm_out;
      @(negedge clk);
    end
    check("R3", "high samples while disabled with full duty active", highs, 0);
  endtask

  task automatic t_no_commit();
    run_pattern("R6", 1, 3, 1);
    stage(0, 1, 0);
    wr(8'h00, 0);
    wr(8'h00, 1);
    sample_cmp("R6", 16, 1, 3, 1);
  endtask

  task automatic t_boundary();
    logic [15:0] seq = 16'b1111_0000_1000_1000;
    logic [15:0] got;
    wr(8'h00, 0);
    stage(0, 7, 3);
    commit();
    stage(0, 3, 0);
    wr(8'h00, 1);
    for (int i = 0; i < 16; i++) begin
      got[15 - i] = pwm_out;
      if (i == 0) begin bus_addr = 8'h08; bus_wdata = 1; bus_we = 1'b1; end
      if (i == 1) bus_wdata = 0;
      if (i == 2) bus_we = 1'b0;
      @(negedge clk);
    end
    check("R7", "16-sample sequence across a running commit", got, seq);
  endtask

  task automatic t_restart();
    wr(8'h00, 0);
    stage(0, 7, 3);
    commit();
    wr(8'h00, 1);
    repeat (4) @(negedge clk);
    wr(8'h00, 0);
    wr(8'h00, 1);
    sample_cmp("R9", 16, 0, 7, 3);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_patterns();
    t_disabled_low();
    t_no_commit();
    t_boundary();
    t_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule